// File: doc/BRIEF.md
# Fully Associative Data Translation Buffer

This block keeps a small set of recently used virtual-to-physical page mappings so that a load or store can be translated without going to the page table. Every stored virtual page number is compared against the incoming address at the same time. A translation needs a stored mapping and the right permission for the access. When both are present, the block returns the physical address: the stored physical page number joined to the page offset, which passes through unchanged. If no mapping is stored, the block reports a miss. If a mapping is stored but the access type is not allowed, the block reports a protection fault.

A miss raises a walk request that carries the missing virtual page number. The request is held until a fill arrives. A separate fill port installs the mapping returned by the walker, together with its permission bits. The entry to replace is an empty slot when one exists, otherwise the least recently used mapping. Write hits mark their page dirty, and the dirty state is reported with each hit. A flush input empties the whole buffer in one cycle.

Lookup results are combinational from the lookup inputs and the stored state. Fills, flushes, recency updates and dirty updates take effect at the next rising clock edge.

Top module: `xlat_tlb`

## Requirements
- R1: The buffer holds 32 mappings at once, and any of them can be hit from any slot by its 20-bit virtual page number (address bits 31:12 for a 4 KB page).
- R2: On a hit, `lk_pa` equals the stored physical page number in bits 31:12 and the unchanged address bits 11:0 of `lk_va`. `lk_pa` is zero whenever `lk_hit` is low.
- R3: A read lookup (`lk_write`=0) that matches an entry whose read-permission bit is clear raises `lk_fault`. A write lookup (`lk_write`=1) that matches an entry whose write-permission bit is clear also raises `lk_fault`. A fault reports no hit, no miss, a zero address and a zero dirty flag.
- R4: When `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low. When `lk_valid` is high, exactly one of them is high.
- R5: A miss while no walk is pending raises `walk_req` from the next cycle, with `walk_vpn` set to the missing page number. Both hold, and later misses do not change `walk_vpn`, until a fill or flush clears the request at the next edge.
- R6: A fill installs its mapping and permissions with the dirty bit clear. A fill whose page number is already present overwrites that entry in place, so no second copy is made.
- R7: While any slot is empty, a fill takes an empty slot and evicts no valid mapping.
- R8: When the buffer is full, a fill replaces the least recently used mapping. Recency is refreshed by fills and by permitted hits only. A faulting lookup does not refresh recency.
- R9: A permitted write hit sets the entry's dirty bit. `lk_dirty` reports the entry's dirty bit as it was before the current lookup.
- R10: A flush invalidates every entry at the next edge and cancels any pending walk request. A fill presented in the same cycle as a flush is discarded.
- R11: When a fill and a lookup arrive in the same cycle, the lookup result is still reported, but the lookup's dirty and recency updates are dropped.
- R12: After reset, every entry is invalid and `walk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_write | input | 1 | Lookup access type: 1 write, 0 read |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No entry holds this page |
| lk_fault | output | 1 | Entry found but access type not permitted |
| lk_pa | output | 32 | Translated physical address, zero unless hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this lookup |
| walk_req | output | 1 | Page-table walk wanted |
| walk_vpn | output | 20 | Virtual page number to walk |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_rd_ok | input | 1 | Read permission of the new mapping |
| fill_wr_ok | input | 1 | Write permission of the new mapping |

## Verification
The bench targets the replacement corner cases. A faulting lookup on the least recently used page must not save it from eviction; a design that refreshed recency on faults would evict a different page, and a later lookup would hit where a miss is expected. A refill of a page that is already stored must replace that entry; a design that allocated a second slot would show a stale physical page or drop an unrelated mapping. The bench also aims at collisions in a single cycle: a flush together with a fill, and a fill together with a write hit. A design with the wrong precedence would keep a mapping that should be gone, or would set a dirty flag that must stay clear. A cycle-accurate behavioural model also runs through thousands of random mixed lookups, fills and flushes over a page pool larger than the buffer, so eviction happens continuously.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int unsigned DEF_ENTRIES   = 32;
    localparam int unsigned DEF_VA_W      = 32;
    localparam int unsigned DEF_PA_W      = 32;
    localparam int unsigned DEF_PAGE_BITS = 12;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_FAULT = 2'd3
    } lk_result_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned KEY_W   = 20,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]              probe,
    output logic                          found,
    output logic [IDX_W-1:0]              index
);
    logic [ENTRIES-1:0] eq;

    // One comparator per slot, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (keys[g] == probe);
    end

    always_comb begin
        index = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) index = IDX_W'(i);
        end
    end

    assign found = |eq;
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);
    // Each slot holds its age rank: 0 is most recent, ENTRIES-1 is oldest.
    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] rank;
    } age_state_t;

    age_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    s_d.rank[i] = '0;
                end else if (s_q.rank[i] < s_q.rank[touch_idx]) begin
                    s_d.rank[i] = s_q.rank[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (s_q.rank[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) s_q.rank[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   oldest_idx,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign any_free   = ~&valid;
    assign victim_idx = any_free ? free_idx : oldest_idx;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES   = DEF_ENTRIES,
    parameter int unsigned VA_W      = DEF_VA_W,
    parameter int unsigned PA_W      = DEF_PA_W,
    parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
    localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
    localparam int unsigned PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_dirty,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd_ok,
    input  logic             fill_wr_ok
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            rd_ok;
        logic [ENTRIES-1:0]            wr_ok;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic                          walk_pend;
        logic [VPN_W-1:0]              walk_vpn;
    } tlb_state_t;

    tlb_state_t s_d, s_q;

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_found;
    logic [IDX_W-1:0] lk_idx;
    logic             fill_found;
    logic [IDX_W-1:0] fill_idx;
    logic [IDX_W-1:0] oldest_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] fill_tgt;
    logic             permitted;
    lk_result_e       result;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;

    assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];

    // Lookup search across all slots.
    xlat_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
        .valid (s_q.valid),
        .keys  (s_q.vpn),
        .probe (lk_vpn),
        .found (lk_found),
        .index (lk_idx)
    );

    // Fill search, so a page already present is rewritten in place.
    xlat_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_fill_match (
        .valid (s_q.valid),
        .keys  (s_q.vpn),
        .probe (fill_vpn),
        .found (fill_found),
        .index (fill_idx)
    );

    xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .oldest_idx (oldest_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid      (s_q.valid),
        .oldest_idx (oldest_idx),
        .victim_idx (victim_idx)
    );

    assign fill_tgt  = fill_found ? fill_idx : victim_idx;
    assign permitted = lk_write ? s_q.wr_ok[lk_idx] : s_q.rd_ok[lk_idx];

    always_comb begin
        if (!lk_valid)      result = LK_IDLE;
        else if (!lk_found) result = LK_MISS;
        else if (permitted) result = LK_HIT;
        else                result = LK_FAULT;
    end

    assign lk_hit   = (result == LK_HIT);
    assign lk_miss  = (result == LK_MISS);
    assign lk_fault = (result == LK_FAULT);
    assign lk_pa    = lk_hit ? {s_q.ppn[lk_idx], lk_va[PAGE_BITS-1:0]} : '0;
    assign lk_dirty = lk_hit & s_q.dirty[lk_idx];
    assign walk_req = s_q.walk_pend;
    assign walk_vpn = s_q.walk_vpn;

    // Next state. Precedence: flush, then fill, then lookup side effects.
    always_comb begin
        s_d       = s_q;
        touch     = 1'b0;
        touch_idx = '0;
        if (flush) begin
            s_d.valid     = '0;
            s_d.walk_pend = 1'b0;
        end else if (fill_valid) begin
            s_d.valid[fill_tgt] = 1'b1;
            s_d.rd_ok[fill_tgt] = fill_rd_ok;
            s_d.wr_ok[fill_tgt] = fill_wr_ok;
            s_d.dirty[fill_tgt] = 1'b0;
            s_d.vpn[fill_tgt]   = fill_vpn;
            s_d.ppn[fill_tgt]   = fill_ppn;
            s_d.walk_pend       = 1'b0;
            touch               = 1'b1;
            touch_idx           = fill_tgt;
        end else begin
            if (result == LK_HIT) begin
                touch     = 1'b1;
                touch_idx = lk_idx;
                if (lk_write) s_d.dirty[lk_idx] = 1'b1;
            end
            if (result == LK_MISS && !s_q.walk_pend) begin
                s_d.walk_pend = 1'b1;
                s_d.walk_vpn  = lk_vpn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/xlat_tlb_checks.sv
module xlat_tlb_checks #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned PAGE_BITS = 12,
    localparam int unsigned VPN_W    = VA_W - PAGE_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_valid,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_va,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic [PA_W-1:0]  lk_pa,
    input logic             lk_dirty,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn
);
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[PAGE_BITS-1:0] == lk_va[PAGE_BITS-1:0]);

    a_r3_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_pa == '0 && !lk_dirty));

    a_r5_walk_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && !walk_req && !flush && !fill_valid) |=>
            (walk_req && walk_vpn == $past(lk_va[VA_W-1:PAGE_BITS])));

    a_r5_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !flush && !fill_valid) |=> (walk_req && $stable(walk_vpn)));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!walk_req && !lk_hit && !lk_fault));

    a_r6_fill_present: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            !(lk_valid && lk_va[VA_W-1:PAGE_BITS] == $past(fill_vpn) && lk_miss));

    a_r9_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !fill_valid && !flush) |=>
            (!(lk_hit && lk_va[VA_W-1:PAGE_BITS] == $past(lk_va[VA_W-1:PAGE_BITS])) || lk_dirty));
endmodule

bind xlat_tlb xlat_tlb_checks #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_checks (.*);

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty, walk_req;
    logic [31:0] lk_pa;
    logic [19:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_rd_ok = 1'b0;
    logic        fill_wr_ok = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cycles = 0;

    always #2 clk = ~clk;

    xlat_tlb dut_i (.*);

    // ---------------- reference model ----------------
    bit        m_valid [N];
    bit        m_rd    [N];
    bit        m_wr    [N];
    bit        m_dirty [N];
    bit [19:0] m_vpn   [N];
    bit [19:0] m_ppn   [N];
    int        m_age[$];
    bit        m_pend;
    bit [19:0] m_pvpn;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_age.delete();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_dirty[i] = 0;
            m_vpn[i] = '0;  m_ppn[i] = '0;
            m_age.push_back(i);
        end
        m_pend = 0;
        m_pvpn = '0;
    endtask

    task automatic m_touch(int idx);
        for (int p = 0; p < m_age.size(); p++) begin
            if (m_age[p] == idx) begin
                m_age.delete(p);
                break;
            end
        end
        m_age.push_front(idx);
    endtask

    function automatic int m_find(bit [19:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    initial m_reset();

    always @(negedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else if (!done) begin
            int        mi;
            bit        ok_acc, e_hit, e_miss, e_fault, e_dirty;
            bit [31:0] e_pa;
            mi      = m_find(lk_va[31:12]);
            ok_acc  = (mi >= 0) && (lk_write ? m_wr[mi] : m_rd[mi]);
            e_hit   = lk_valid && ok_acc;
            e_fault = lk_valid && (mi >= 0) && !ok_acc;
            e_miss  = lk_valid && (mi < 0);
            e_pa    = e_hit ? {m_ppn[mi], lk_va[11:0]} : 32'h0;
            e_dirty = e_hit ? m_dirty[mi] : 1'b0;
            chk({lk_hit, lk_miss, lk_fault} == {e_hit, e_miss, e_fault}, "R4 model flags",
                {lk_hit, lk_miss, lk_fault}, {e_hit, e_miss, e_fault});
            chk(lk_pa == e_pa, "R2 model address", lk_pa, e_pa);
            chk(lk_dirty == e_dirty, "R9 model dirty", lk_dirty, e_dirty);
            chk({walk_req, walk_vpn} == {m_pend, m_pvpn}, "R5 model walk",
                {walk_req, walk_vpn}, {m_pend, m_pvpn});
            // state update for the coming edge
            if (flush) begin
                for (int i = 0; i < N; i++) m_valid[i] = 0;
                m_pend = 0;
            end else if (fill_valid) begin
                int t;
                t = m_find(fill_vpn);
                if (t < 0) begin
                    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) t = i;
                end
                if (t < 0) t = m_age[m_age.size() - 1];
                m_valid[t] = 1; m_rd[t] = fill_rd_ok; m_wr[t] = fill_wr_ok;
                m_dirty[t] = 0; m_vpn[t] = fill_vpn;  m_ppn[t] = fill_ppn;
                m_touch(t);
                m_pend = 0;
            end else begin
                if (e_hit) begin
                    m_touch(mi);
                    if (lk_write) m_dirty[mi] = 1;
                end
                if (e_miss && !m_pend) begin
                    m_pend = 1;
                    m_pvpn = lk_va[31:12];
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(bit fl, bit lv, bit lw, bit [31:0] va,
                         bit fv, bit [19:0] fvpn, bit [19:0] fppn, bit fr, bit fw);
        @(posedge clk);
        #1;
        flush = fl; lk_valid = lv; lk_write = lw; lk_va = va;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
        fill_rd_ok = fr; fill_wr_ok = fw;
        @(negedge clk);
        #0.5;
    endtask

    task automatic look(bit wr, bit [31:0] va);
        drive(0, 1, wr, va, 0, '0, '0, 0, 0);
    endtask

    task automatic fill(bit [19:0] v, bit [19:0] p, bit r, bit w);
        drive(0, 0, 0, '0, 1, v, p, r, w);
    endtask

    task automatic idle();
        drive(0, 0, 0, '0, 0, '0, '0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12: empty after reset
        look(0, 32'h0000_5123);
        chk(lk_miss && !lk_hit && !lk_fault, "R12 lookup after reset misses", {lk_hit, lk_miss, lk_fault}, 3'b010);
        chk(!walk_req, "R12 no walk after reset", walk_req, 0);
        look(0, 32'h0000_7000);
        chk(walk_req && walk_vpn == 20'h5, "R5 walk raised with vpn", {walk_req, walk_vpn}, {1'b1, 20'h5});
        idle();
        chk(walk_vpn == 20'h5, "R5 later miss keeps vpn", walk_vpn, 20'h5);
        chk({lk_hit, lk_miss, lk_fault} == 3'b000, "R4 idle flags low", {lk_hit, lk_miss, lk_fault}, 0);

        fill(20'h5, 20'hABCDE, 1, 1);
        look(0, 32'h0000_5123);
        chk(lk_hit && lk_pa == 32'hABCD_E123, "R2 hit address", lk_pa, 32'hABCD_E123);
        chk(!lk_dirty, "R6 fill clears dirty", lk_dirty, 0);
        chk(!walk_req, "R5 fill clears walk", walk_req, 0);
        look(1, 32'h0000_5FFF);
        chk(lk_hit && !lk_dirty, "R9 dirty reported before write", lk_dirty, 0);
        look(0, 32'h0000_5000);
        chk(lk_dirty && lk_pa == 32'hABCD_E000, "R9 write hit set dirty", lk_dirty, 1);

        fill(20'h5, 20'h13579, 1, 0);
        look(0, 32'h0000_5456);
        chk(lk_hit && lk_pa == 32'h1357_9456 && !lk_dirty, "R6 refill overwrites in place", lk_pa, 32'h1357_9456);
        look(1, 32'h0000_5456);
        chk(lk_fault && !lk_hit && !lk_miss && lk_pa == 0, "R3 write without permission faults",
            {lk_hit, lk_miss, lk_fault, lk_pa}, {3'b001, 32'h0});
        fill(20'h9, 20'h24680, 0, 1);
        look(0, 32'h0000_9010);
        chk(lk_fault && lk_pa == 0, "R3 read without permission faults", {lk_fault, lk_pa}, {1'b1, 32'h0});
        look(1, 32'h0000_9010);
        chk(lk_hit && lk_pa == 32'h2468_0010, "R2 write hit address", lk_pa, 32'h2468_0010);

        // R11: fill and write hit together; the dirty update is dropped
        fill(20'h9, 20'h24680, 0, 1);
        drive(0, 1, 1, 32'h0000_9010, 1, 20'h77, 20'h1, 1, 1);
        chk(lk_hit, "R11 lookup still reported with fill", lk_hit, 1);
        look(1, 32'h0000_9010);
        chk(lk_hit && !lk_dirty, "R11 dirty update dropped", lk_dirty, 0);

        // R10: flush together with fill, with a walk pending
        look(0, 32'hEEEE_E000);
        idle();
        chk(walk_req, "R10 walk pending before flush", walk_req, 1);
        drive(1, 0, 0, '0, 1, 20'h300, 20'h1, 1, 1);
        look(0, 32'h0030_0000);
        chk(lk_miss, "R10 fill during flush discarded", lk_miss, 1);
        chk(!walk_req, "R10 flush cancels walk", walk_req, 0);
        look(0, 32'h0000_5000);
        chk(lk_miss, "R10 all entries invalidated", lk_miss, 1);

        // R1 R7: fill 32 pages after flush, all must hit
        fill(20'h100, 20'h80100, 1, 0);
        for (int k = 1; k < N; k++) fill(20'h100 + 20'(k), 20'h80100 + 20'(k), 1, 1);
        for (int k = 0; k < N; k++) begin
            look(0, {20'h100 + 20'(k), 12'h0AB});
            chk(lk_hit && lk_pa == {20'h80100 + 20'(k), 12'h0AB}, "R1 R7 full set hits",
                lk_pa, {20'h80100 + 20'(k), 12'h0AB});
        end

        // R8: faulting access does not refresh recency
        look(1, 32'h0010_0000);
        chk(lk_fault, "R8 fault on oldest page", lk_fault, 1);
        fill(20'h200, 20'h1, 1, 1);
        look(0, 32'h0010_0000);
        chk(lk_miss, "R8 oldest page evicted", lk_miss, 1);
        look(0, 32'h0010_1000);
        chk(lk_hit, "R8 next page kept", lk_hit, 1);
        fill(20'h201, 20'h2, 1, 1);
        look(0, 32'h0010_2000);
        chk(lk_miss, "R8 new oldest evicted", lk_miss, 1);
        look(0, 32'h0010_1000);
        chk(lk_hit, "R8 refreshed page kept", lk_hit, 1);
        look(0, 32'h0020_1000);
        chk(lk_hit && lk_pa == 32'h0000_2000, "R8 fill landed", lk_pa, 32'h0000_2000);

        // random mix compared against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            bit        fl, lv, lw, fv, fr, fw;
            bit [19:0] v;
            int        r;
            r  = $urandom_range(0, 99);
            fl = (r < 2);
            fv = (r >= 2 && r < 30);
            lv = ($urandom_range(0, 9) < 7);
            lw = $urandom_range(0, 1);
            fr = ($urandom_range(0, 3) != 0);
            fw = ($urandom_range(0, 3) != 0);
            v  = 20'h400 + 20'($urandom_range(0, 39));
            drive(fl, lv, lw, {20'h400 + 20'($urandom_range(0, 39)), 12'($urandom)},
                  fv, v, 20'($urandom), fr, fw);
        end
        idle();
        finish_run();
    end
endmodule